// File: doc/BRIEF.md
# Vector-Length Scaled Address Adder

This execute unit takes one 32-bit instruction word per cycle and recognises a single operation. That operation reads a 64-bit scalar register and adds to it a signed immediate multiplied by the current vector register size in bytes. It then writes the 64-bit sum to a destination register. The vector size is a runtime input given in bits. The unit divides it by eight and scales it by a shift-and-add network, not by a general multiplier. Register index 31 names the stack pointer on both the read side and the write side.

The unit holds 32 storage entries. Entries 0 to 30 are general registers and entry 31 is the stack pointer. A test port loads any entry and reads any entry back. Two feature inputs decide how a matching word is handled. If the scalable vector feature is absent, the word is reported as undefined. If the feature is present but disabled, the word raises an access trap. In both fault cases no register changes.

Each result or fault appears on registered outputs exactly one cycle after the word is offered. The instruction stream has no back-pressure: the unit accepts a word in every cycle in which `op_valid` is high, and it never stalls. The unit has no ready output, so the source needs no flow control. The time to execute never depends on operand values.

Top module: `vls_exec`

## Requirements
- R1: A word is recognised only if bits [31:21] equal 11'b00000100001 and bits [15:11] equal 5'b01010, and only while `op_valid` is high. Any other word produces no writeback, no fault and no register change.
- R2: The source index is taken from bits [20:16], the immediate from bits [10:5] as a 6-bit two's-complement value, and the destination index from bits [4:0]. `wb_index` reports the destination index.
- R3: The result is source + imm × (`vec_bits` / 8), taken modulo 2^64. No flag is produced.
- R4: A source index of 31 reads the stack pointer, which is entry 31.
- R5: A destination index of 31 writes the stack pointer, and `wb_to_sp` is then 1. For any other destination index, only that general register changes and `wb_to_sp` is 0.
- R6: A recognised word with `feat_present` = 0 sets `flt_undef` = 1 and `wb_valid` = 0, and writes no register.
- R7: A recognised word with `feat_present` = 1 and `feat_enabled` = 0 sets `flt_trap` = 1, with `wb_valid` = 0 and `flt_undef` = 0, and writes no register.
- R8: The outputs are registered and valid in the single cycle after the word is sampled. At most one of `wb_valid`, `flt_undef` and `flt_trap` is high in any cycle, and all three are low after a cycle with `op_valid` low.
- R9: Reset clears all 32 entries and all outputs to zero.
- R10: While `dbg_we` is high, the test port writes `dbg_wdata` into entry `dbg_widx` at the clock edge. `dbg_rdata` shows entry `dbg_ridx` combinationally. If the test port and an instruction write in the same cycle, the instruction write wins.
- R11: `vec_bits` must be a multiple of 128 between 128 and 2048 whenever `op_valid` is high. The full product range is supported: imm −32 at 2048 bits gives −8192, and imm 31 at 2048 bits gives 7936.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction word present this cycle |
| op_word | input | 32 | Instruction word |
| vec_bits | input | 12 | Current vector length in bits |
| feat_present | input | 1 | Scalable vector feature implemented |
| feat_enabled | input | 1 | Scalable vector feature enabled |
| dbg_we | input | 1 | Test port write strobe |
| dbg_widx | input | 5 | Test port write index (31 = stack pointer) |
| dbg_wdata | input | 64 | Test port write data |
| dbg_ridx | input | 5 | Test port read index |
| dbg_rdata | output | 64 | Test port read data |
| wb_valid | output | 1 | Writeback performed |
| wb_index | output | 5 | Destination index written |
| wb_to_sp | output | 1 | Writeback targeted the stack pointer |
| wb_data | output | 64 | Value written |
| flt_undef | output | 1 | Undefined-instruction fault |
| flt_trap | output | 1 | Disabled-feature access trap |

## Verification
Each result and each fault is due in the one cycle that follows the clock edge that samples `op_valid`. The new register contents can be read through the test port from that same cycle. The bench drives inputs on the falling edge and removes `op_valid` on the next falling edge, with one rising edge in between. It checks the outputs and the read port at that second falling edge. For the pulse-width checks it looks one more cycle later and expects all outputs to be low again.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int XLEN   = 64;
  localparam int IDX_W  = 5;
  localparam int IMM_W  = 6;
  localparam int NENT   = 1 << IDX_W;

  typedef logic [IDX_W-1:0] ridx_t;
  typedef logic [XLEN-1:0]  xword_t;

  localparam logic [10:0] OPC_HI  = 11'b00000100001;
  localparam logic [4:0]  OPC_MID = 5'b01010;
  localparam ridx_t       SP_IDX  = ridx_t'(NENT - 1);

  typedef struct packed {
    logic              match;
    ridx_t             src;
    ridx_t             dst;
    logic [IMM_W-1:0]  imm;
  } dec_t;

  typedef enum logic [1:0] {
    OC_NONE  = 2'd0,
    OC_WB    = 2'd1,
    OC_UNDEF = 2'd2,
    OC_TRAP  = 2'd3
  } outcome_e;
endpackage

// File: rtl/vls_decode.sv
module vls_decode
  import vls_pkg::*;
(
  input  logic [31:0] word,
  output dec_t        dec
);
  always_comb begin
    dec.match = (word[31:21] == OPC_HI) && (word[15:11] == OPC_MID);
    dec.src   = word[20:16];
    dec.imm   = word[10:5];
    dec.dst   = word[4:0];
  end
endmodule

// File: rtl/vls_scale.sv
// Signed immediate times byte count, as a fixed shift-and-add tree.
module vls_scale #(
  parameter int VL_W  = 12,
  parameter int IMM_W = 6,
  parameter int XW    = 64
) (
  input  logic [VL_W-1:0]  vec_bits,
  input  logic [IMM_W-1:0] imm,
  output logic [XW-1:0]    offset
);
  localparam int PAD = XW - VL_W;

  logic [XW-1:0] vl_ext;
  logic [XW-1:0] bytes;
  logic [XW-1:0] term [IMM_W];
  logic [XW-1:0] pos_sum;

  assign vl_ext = {{PAD{1'b0}}, vec_bits};
  assign bytes  = vl_ext >> 3;

  for (genvar k = 0; k < IMM_W; k++) begin : g_term
    assign term[k] = imm[k] ? (bytes << k) : '0;
  end

  // Every partial product is always summed: no data-dependent shortcut.
  always_comb begin
    pos_sum = '0;
    for (int k = 0; k < IMM_W - 1; k++) pos_sum = pos_sum + term[k];
  end

  // The top immediate bit carries negative weight in two's complement.
  assign offset = pos_sum - term[IMM_W-1];
endmodule

// File: rtl/vls_regfile.sv
module vls_regfile
  import vls_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   we,
  input  ridx_t  widx,
  input  xword_t wdata,
  input  ridx_t  ra_idx,
  output xword_t ra_data,
  input  ridx_t  rb_idx,
  output xword_t rb_data
);
  xword_t ent_q [NENT];

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    xword_t q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          q <= '0;
      else if (we && (widx == ridx_t'(i))) q <= wdata;
    end
    assign ent_q[i] = q;
  end

  assign ra_data = ent_q[ra_idx];
  assign rb_data = ent_q[rb_idx];
endmodule

// File: rtl/vls_exec.sv
module vls_exec
  import vls_pkg::*;
#(
  parameter int VL_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [31:0]     op_word,
  input  logic [VL_W-1:0] vec_bits,
  input  logic            feat_present,
  input  logic            feat_enabled,
  input  logic            dbg_we,
  input  logic [4:0]      dbg_widx,
  input  logic [63:0]     dbg_wdata,
  input  logic [4:0]      dbg_ridx,
  output logic [63:0]     dbg_rdata,
  output logic            wb_valid,
  output logic [4:0]      wb_index,
  output logic            wb_to_sp,
  output logic [63:0]     wb_data,
  output logic            flt_undef,
  output logic            flt_trap
);
  dec_t     dec;
  xword_t   src_val;
  xword_t   offset;
  xword_t   sum;
  outcome_e oc;
  logic     exec_we;
  logic     rf_we;
  ridx_t    rf_widx;
  xword_t   rf_wdata;

  vls_decode u_dec (.word(op_word), .dec(dec));

  vls_scale #(.VL_W(VL_W), .IMM_W(IMM_W), .XW(XLEN)) u_scale (
    .vec_bits (vec_bits),
    .imm      (dec.imm),
    .offset   (offset)
  );

  vls_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .widx    (rf_widx),
    .wdata   (rf_wdata),
    .ra_idx  (dec.src),
    .ra_data (src_val),
    .rb_idx  (dbg_ridx),
    .rb_data (dbg_rdata)
  );

  assign sum = src_val + offset;

  always_comb begin
    oc = OC_NONE;
    if (op_valid && dec.match) begin
      if (!feat_present)      oc = OC_UNDEF;
      else if (!feat_enabled) oc = OC_TRAP;
      else                    oc = OC_WB;
    end
  end

  assign exec_we  = (oc == OC_WB);
  assign rf_we    = exec_we || dbg_we;
  assign rf_widx  = exec_we ? dec.dst : dbg_widx;
  assign rf_wdata = exec_we ? sum : dbg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid  <= 1'b0;
      wb_index  <= '0;
      wb_to_sp  <= 1'b0;
      wb_data   <= '0;
      flt_undef <= 1'b0;
      flt_trap  <= 1'b0;
    end else begin
      wb_valid  <= exec_we;
      wb_index  <= exec_we ? dec.dst : '0;
      wb_to_sp  <= exec_we && (dec.dst == SP_IDX);
      wb_data   <= exec_we ? sum : '0;
      flt_undef <= (oc == OC_UNDEF);
      flt_trap  <= (oc == OC_TRAP);
    end
  end
endmodule

// File: rtl/vls_exec_checker.sv
module vls_exec_checker #(
  parameter int VL_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [VL_W-1:0] vec_bits,
  input logic            feat_present,
  input logic            feat_enabled,
  input logic            wb_valid,
  input logic            flt_undef,
  input logic            flt_trap
);
  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_valid, flt_undef, flt_trap}));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!wb_valid && !flt_undef && !flt_trap));

  assert_absent_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !feat_present) |=> (!wb_valid && !flt_trap));

  assert_undef_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_undef |-> $past(op_valid && !feat_present));

  assert_trap_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flt_trap |-> $past(op_valid && feat_present && !feat_enabled));

  assert_disabled_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && feat_present && !feat_enabled) |=> (!wb_valid && !flt_undef));

  assert_vl_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> ((vec_bits != '0) && (vec_bits[6:0] == 7'd0) &&
                  (vec_bits <= VL_W'(2048))));
endmodule

bind vls_exec vls_exec_checker #(.VL_W(VL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .vec_bits     (vec_bits),
  .feat_present (feat_present),
  .feat_enabled (feat_enabled),
  .wb_valid     (wb_valid),
  .flt_undef    (flt_undef),
  .flt_trap     (flt_trap)
);

// File: tb/vls_exec_tb.sv
module vls_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [31:0] op_word = '0;
  logic [11:0] vec_bits = 12'd512;
  logic        feat_present = 1'b1;
  logic        feat_enabled = 1'b1;
  logic        dbg_we = 1'b0;
  logic [4:0]  dbg_widx = '0;
  logic [63:0] dbg_wdata = '0;
  logic [4:0]  dbg_ridx = '0;
  logic [63:0] dbg_rdata;
  logic        wb_valid, wb_to_sp, flt_undef, flt_trap;
  logic [4:0]  wb_index;
  logic [63:0] wb_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  vls_exec dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
    .vec_bits(vec_bits), .feat_present(feat_present), .feat_enabled(feat_enabled),
    .dbg_we(dbg_we), .dbg_widx(dbg_widx), .dbg_wdata(dbg_wdata),
    .dbg_ridx(dbg_ridx), .dbg_rdata(dbg_rdata),
    .wb_valid(wb_valid), .wb_index(wb_index), .wb_to_sp(wb_to_sp),
    .wb_data(wb_data), .flt_undef(flt_undef), .flt_trap(flt_trap)
  );

  function automatic logic [31:0] enc(input logic [4:0] rn, input int imm, input logic [4:0] rd);
    logic [5:0] i6;
    i6 = 6'(imm);
    return {11'b00000100001, rn, 5'b01010, i6, rd};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [4:0] idx, input logic [63:0] val);
    @(negedge clk);
    dbg_we = 1'b1; dbg_widx = idx; dbg_wdata = val;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic peek(input logic [4:0] idx, output logic [63:0] val);
    dbg_ridx = idx;
    #1;
    val = dbg_rdata;
  endtask

  // Offer one word; return at the falling edge where its outputs are due.
  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    op_valid = 1'b1; op_word = w;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    chk("R9 wb_valid", 64'(wb_valid), 0);
    chk("R9 flt_undef", 64'(flt_undef), 0);
    chk("R9 flt_trap", 64'(flt_trap), 0);
    chk("R9 wb_data", wb_data, 0);
    peek(5'd7, v);  chk("R9 entry7", v, 0);
    peek(5'd31, v); chk("R9 stack ptr", v, 0);
  endtask

  task automatic t_test_port();
    logic [63:0] v;
    poke(5'd12, 64'hDEAD_BEEF_0123_4567);
    peek(5'd12, v); chk("R10 test port readback", v, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_basic();
    logic [63:0] v;
    poke(5'd1, 64'd1000);
    vec_bits = 12'd512;
    issue(enc(5'd1, 3, 5'd2));
    chk("R8 wb_valid one cycle later", 64'(wb_valid), 1);
    chk("R2 wb_index", 64'(wb_index), 2);
    chk("R3 basic sum", wb_data, 64'd1192);
    chk("R5 wb_to_sp low for gpr", 64'(wb_to_sp), 0);
    peek(5'd2, v); chk("R3 dest register", v, 64'd1192);
    peek(5'd31, v); chk("R5 stack ptr untouched", v, 0);
    @(negedge clk);
    chk("R8 wb_valid drops", 64'(wb_valid), 0);
  endtask

  task automatic t_extremes();
    logic [63:0] v;
    poke(5'd3, 64'h10000);
    vec_bits = 12'd2048;
    issue(enc(5'd3, -32, 5'd5));
    chk("R11 imm -32 at 2048", wb_data, 64'hE000);
    issue(enc(5'd0, 31, 5'd6));
    chk("R11 imm 31 at 2048", wb_data, 64'd7936);
    vec_bits = 12'd128;
    poke(5'd4, 64'hFFFF_FFFF_FFFF_FFF0);
    issue(enc(5'd4, 1, 5'd4));
    chk("R3 wrap modulo 2^64", wb_data, 64'd0);
    peek(5'd4, v); chk("R3 wrapped register", v, 64'd0);
  endtask

  task automatic t_stack();
    logic [63:0] v;
    poke(5'd31, 64'h8000);
    poke(5'd30, 64'h5);
    vec_bits = 12'd256;
    issue(enc(5'd31, -1, 5'd31));
    chk("R4 source 31 reads stack ptr", wb_data, 64'h7FE0);
    chk("R5 wb_to_sp", 64'(wb_to_sp), 1);
    peek(5'd31, v); chk("R5 stack ptr written", v, 64'h7FE0);
    peek(5'd30, v); chk("R5 entry30 untouched", v, 64'h5);
  endtask

  task automatic t_nonmatch();
    logic [63:0] v;
    logic [31:0] w;
    poke(5'd8, 64'h77);
    w = enc(5'd8, 2, 5'd8);
    w[12] = ~w[12];
    issue(w);
    chk("R1 bad mid bits no wb", 64'(wb_valid), 0);
    chk("R1 bad mid bits no fault", 64'({flt_undef, flt_trap}), 0);
    w = enc(5'd8, 2, 5'd8);
    w[26] = 1'b0;
    issue(w);
    chk("R1 bad high bits no wb", 64'(wb_valid), 0);
    peek(5'd8, v); chk("R1 register unchanged", v, 64'h77);
    @(negedge clk);
    op_word = enc(5'd8, 2, 5'd8);
    @(negedge clk);
    chk("R1 valid low no wb", 64'(wb_valid), 0);
    peek(5'd8, v); chk("R1 valid low unchanged", v, 64'h77);
  endtask

  task automatic t_faults();
    logic [63:0] v;
    poke(5'd9, 64'h100);
    vec_bits = 12'd512;
    feat_present = 1'b0;
    issue(enc(5'd9, 1, 5'd9));
    chk("R6 flt_undef", 64'(flt_undef), 1);
    chk("R6 no wb", 64'(wb_valid), 0);
    peek(5'd9, v); chk("R6 register unchanged", v, 64'h100);
    feat_present = 1'b1; feat_enabled = 1'b0;
    issue(enc(5'd9, 1, 5'd9));
    chk("R7 flt_trap", 64'(flt_trap), 1);
    chk("R7 no undef", 64'(flt_undef), 0);
    chk("R7 no wb", 64'(wb_valid), 0);
    peek(5'd9, v); chk("R7 register unchanged", v, 64'h100);
    feat_enabled = 1'b1;
    @(negedge clk);
    chk("R8 trap one cycle", 64'(flt_trap), 0);
  endtask

  task automatic t_collide();
    logic [63:0] v;
    poke(5'd10, 64'h40);
    vec_bits = 12'd128;
    @(negedge clk);
    op_valid = 1'b1; op_word = enc(5'd10, 2, 5'd10);
    dbg_we = 1'b1; dbg_widx = 5'd10; dbg_wdata = 64'h9999;
    @(negedge clk);
    op_valid = 1'b0; dbg_we = 1'b0;
    peek(5'd10, v); chk("R10 instruction write wins", v, 64'h60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_test_port();
    t_basic();
    t_extremes();
    t_stack();
    t_nonmatch();
    t_faults();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule